// File: doc/BRIEF.md
# Pop-free filter and power change sequencer

This block sits between the host control registers and the soft-stepping volume stage of an audio DAC path. Any change that would click if applied at full volume is held back: a toggle of a filter enable (de-emphasis or effects processing) or a power-up or power-down of the datapath. The block first sends the volume stage a mute target. It waits until the stage reports that the applied volume has reached its target. Only then does it make the change, and it then hands the host's own level back as the target.

On power-down the volume ramps to mute before the datapath power-down line is raised. One cycle later a completion flag tells the host that clocks may be stopped. On power-up the datapath leaves power-down while the target is still the host level, and the volume stage ramps up from mute. Requests are levels, so a change that arrives during a sequence is simply seen again once the sequencer is back in its idle state. A pending power-down wins over a pending filter change.

Top module: `softmute_seq`

## Requirements
- R1: During and after reset the block is in the powered-down state: `dp_pwrdn_o`=1, `pd_done_o`=1, `filt_en_o`=0 and `vol_tgt_o`=`MUTE_LVL`.
- R2: With `pwr_on_i`=1 in the powered-down state, at the next edge `dp_pwrdn_o` and `pd_done_o` fall and `vol_tgt_o` becomes `host_lvl_i`. This ramp-up phase lasts until a settled indication is accepted.
- R3: In every ramp phase (mute, unmute, power-down), `vol_settled_i` is ignored in the first cycle of the phase. From the second cycle on, a high `vol_settled_i` ends the phase at the next edge.
- R4: In idle with `pwr_on_i`=1, a `filt_req_i` that differs from `filt_en_o` switches `vol_tgt_o` to `MUTE_LVL` at the next edge and captures `filt_req_i` at that edge. Bit 0 is de-emphasis and bit 1 is effects processing.
- R5: Once mute has settled, the block spends exactly one cycle with the mute target. At the end of that cycle `filt_en_o` takes the captured value, not the live request, and `vol_tgt_o` returns to `host_lvl_i`.
- R6: When the unmute phase settles the block returns to idle. In idle and in the unmute phase, `vol_tgt_o` follows the live `host_lvl_i`, which the block never alters.
- R7: In idle with `pwr_on_i`=0 the target goes to mute. `dp_pwrdn_o` rises only at the edge after an accepted settled indication, and `pd_done_o` rises one cycle after `dp_pwrdn_o`.
- R8: Requests that change during a sequence have no effect until idle is reached. In idle, `pwr_on_i`=0 takes priority over a differing `filt_req_i`.
- R9: In the powered-down state `filt_en_o` loads `filt_req_i` at every edge and `vol_tgt_o` stays `MUTE_LVL`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_i | input | 1 | Host wants the DAC path powered |
| filt_req_i | input | FILT_N | Host filter enables (bit 0 de-emphasis, bit 1 effects) |
| host_lvl_i | input | LVL_W | Host volume level |
| vol_settled_i | input | 1 | Volume stage reports applied level equals target |
| vol_tgt_o | output | LVL_W | Target level sent to the volume stage |
| filt_en_o | output | FILT_N | Filter enables applied to the datapath |
| dp_pwrdn_o | output | 1 | Power-down to the datapath |
| pd_done_o | output | 1 | Power-down sequence complete flag |

## Verification
The bench builds the block with `LVL_W`=7, `FILT_N`=2 and `MUTE_LVL`=0. A mute target of zero is therefore distinct from every host level the stimulus uses. Both filter bits can change together or apart, so the capture at sequence entry can be told apart from a later live request. Because the bench drives the settled line directly, it places the indication in the ignored first ramp cycle and in the accepted second cycle.

// File: rtl/softmute_pkg.sv
package softmute_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUTE_RAMP,
    ST_APPLY,
    ST_UNMUTE_RAMP,
    ST_PD_RAMP,
    ST_PD_DONE
  } seq_st_e;
endpackage

// File: rtl/softmute_fsm.sv
module softmute_fsm
  import softmute_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic req_diff_i,
  input  logic settled_i,
  output logic lat_en_o,
  output logic apply_o,
  output logic pd_state_o,
  output logic host_sel_o,
  output logic pd_done_o
);
  seq_st_e state_q, state_d;
  logic    arm_q;
  logic    ramp;
  logic    acc;

  assign ramp = (state_q == ST_MUTE_RAMP) || (state_q == ST_UNMUTE_RAMP) ||
                (state_q == ST_PD_RAMP);
  // settled is only trusted once the new target has been seen for a cycle
  assign acc  = arm_q && settled_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!pwr_on_i)       state_d = ST_PD_RAMP;
        else if (req_diff_i) state_d = ST_MUTE_RAMP;
      end
      ST_MUTE_RAMP:   if (acc) state_d = ST_APPLY;
      ST_APPLY:       state_d = ST_UNMUTE_RAMP;
      ST_UNMUTE_RAMP: if (acc) state_d = ST_IDLE;
      ST_PD_RAMP:     if (acc) state_d = ST_PD_DONE;
      ST_PD_DONE:     if (pwr_on_i) state_d = ST_UNMUTE_RAMP;
      default:        state_d = ST_PD_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PD_DONE;
      arm_q     <= 1'b0;
      pd_done_o <= 1'b1;
    end else begin
      state_q   <= state_d;
      arm_q     <= ramp && (state_d == state_q);
      pd_done_o <= (state_q == ST_PD_DONE) && (state_d == ST_PD_DONE);
    end
  end

  assign lat_en_o   = (state_q == ST_IDLE) && (state_d == ST_MUTE_RAMP);
  assign apply_o    = (state_q == ST_APPLY);
  assign pd_state_o = (state_q == ST_PD_DONE);
  assign host_sel_o = (state_q == ST_IDLE) || (state_q == ST_UNMUTE_RAMP);

  assert_apply_after_settle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_APPLY) |-> $past(settled_i));
  assert_apply_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_APPLY) |=> (state_q == ST_UNMUTE_RAMP));
  assert_done_implies_pd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_done_o |-> pd_state_o);
endmodule

// File: rtl/softmute_filt.sv
module softmute_filt #(
  parameter int FILT_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILT_N-1:0] req_i,
  input  logic              lat_en_i,
  input  logic              apply_i,
  input  logic              pd_state_i,
  output logic [FILT_N-1:0] en_o
);
  logic [FILT_N-1:0] lat_q;

  for (genvar g = 0; g < FILT_N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q[g] <= 1'b0;
        en_o[g]  <= 1'b0;
      end else begin
        if (lat_en_i)        lat_q[g] <= req_i[g];
        if (apply_i)         en_o[g]  <= lat_q[g];
        else if (pd_state_i) en_o[g]  <= req_i[g];
      end
    end
  end

  assert_filt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!apply_i && !pd_state_i) |=> $stable(en_o));
endmodule

// File: rtl/softmute_tgt.sv
module softmute_tgt #(
  parameter int               LVL_W    = 7,
  parameter logic [LVL_W-1:0] MUTE_LVL = '0
) (
  input  logic             host_sel_i,
  input  logic [LVL_W-1:0] host_lvl_i,
  output logic [LVL_W-1:0] tgt_o
);
  assign tgt_o = host_sel_i ? host_lvl_i : MUTE_LVL;
endmodule

// File: rtl/softmute_seq.sv
module softmute_seq #(
  parameter int               LVL_W    = 7,
  parameter int               FILT_N   = 2,
  parameter logic [LVL_W-1:0] MUTE_LVL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic [FILT_N-1:0] filt_req_i,
  input  logic [LVL_W-1:0]  host_lvl_i,
  input  logic              vol_settled_i,
  output logic [LVL_W-1:0]  vol_tgt_o,
  output logic [FILT_N-1:0] filt_en_o,
  output logic              dp_pwrdn_o,
  output logic              pd_done_o
);
  logic lat_en, apply, pd_state, host_sel, req_diff;

  assign req_diff = (filt_req_i != filt_en_o);

  softmute_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .req_diff_i (req_diff),
    .settled_i  (vol_settled_i),
    .lat_en_o   (lat_en),
    .apply_o    (apply),
    .pd_state_o (pd_state),
    .host_sel_o (host_sel),
    .pd_done_o  (pd_done_o)
  );

  softmute_filt #(.FILT_N(FILT_N)) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (filt_req_i),
    .lat_en_i   (lat_en),
    .apply_i    (apply),
    .pd_state_i (pd_state),
    .en_o       (filt_en_o)
  );

  softmute_tgt #(.LVL_W(LVL_W), .MUTE_LVL(MUTE_LVL)) u_tgt (
    .host_sel_i (host_sel),
    .host_lvl_i (host_lvl_i),
    .tgt_o      (vol_tgt_o)
  );

  assign dp_pwrdn_o = pd_state;

  assert_pwrdn_after_mute_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_pwrdn_o) |-> $past(vol_settled_i && (vol_tgt_o == MUTE_LVL)));
  assert_pwrup_clears_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dp_pwrdn_o) |-> !pd_done_o);
endmodule

// File: tb/softmute_seq_test.sv
module softmute_seq_test;
  localparam int LVL_W  = 7;
  localparam int FILT_N = 2;
  localparam int NV     = 26;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pwr_on = 1'b0;
  logic [FILT_N-1:0] filt_req = '0;
  logic [LVL_W-1:0]  host_lvl = '0;
  logic              settled = 1'b0;
  logic [LVL_W-1:0]  vol_tgt;
  logic [FILT_N-1:0] filt_en;
  logic              dp_pwrdn, pd_done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  softmute_seq #(.LVL_W(LVL_W), .FILT_N(FILT_N), .MUTE_LVL('0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr_on), .filt_req_i(filt_req),
    .host_lvl_i(host_lvl), .vol_settled_i(settled), .vol_tgt_o(vol_tgt),
    .filt_en_o(filt_en), .dp_pwrdn_o(dp_pwrdn), .pd_done_o(pd_done)
  );

  // inputs {pwr, filt, lvl, settled}, expected {vol_tgt, filt_en, dp_pwrdn, pd_done}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 2'b01, 7'd40, 1'b0,  7'd0,  2'b01, 1'b1, 1'b1}, // 0  R9
    {1'b1, 2'b01, 7'd40, 1'b0,  7'd40, 2'b01, 1'b0, 1'b0}, // 1  R2
    {1'b1, 2'b01, 7'd40, 1'b1,  7'd40, 2'b01, 1'b0, 1'b0}, // 2  R3 ignored
    {1'b1, 2'b01, 7'd40, 1'b0,  7'd40, 2'b01, 1'b0, 1'b0}, // 3  R2
    {1'b1, 2'b01, 7'd40, 1'b1,  7'd40, 2'b01, 1'b0, 1'b0}, // 4  R6
    {1'b1, 2'b11, 7'd50, 1'b1,  7'd0,  2'b01, 1'b0, 1'b0}, // 5  R4
    {1'b1, 2'b11, 7'd50, 1'b1,  7'd0,  2'b01, 1'b0, 1'b0}, // 6  R3
    {1'b1, 2'b00, 7'd50, 1'b1,  7'd0,  2'b01, 1'b0, 1'b0}, // 7  R5
    {1'b1, 2'b00, 7'd50, 1'b0,  7'd50, 2'b11, 1'b0, 1'b0}, // 8  R5 captured
    {1'b1, 2'b00, 7'd50, 1'b1,  7'd50, 2'b11, 1'b0, 1'b0}, // 9  R3
    {1'b1, 2'b00, 7'd50, 1'b1,  7'd50, 2'b11, 1'b0, 1'b0}, // 10 R6
    {1'b0, 2'b00, 7'd50, 1'b0,  7'd0,  2'b11, 1'b0, 1'b0}, // 11 R8 priority
    {1'b0, 2'b00, 7'd50, 1'b0,  7'd0,  2'b11, 1'b0, 1'b0}, // 12 R7
    {1'b0, 2'b00, 7'd50, 1'b1,  7'd0,  2'b11, 1'b1, 1'b0}, // 13 R7
    {1'b0, 2'b00, 7'd50, 1'b0,  7'd0,  2'b00, 1'b1, 1'b1}, // 14 R7 R9
    {1'b1, 2'b00, 7'd20, 1'b0,  7'd20, 2'b00, 1'b0, 1'b0}, // 15 R2
    {1'b1, 2'b00, 7'd20, 1'b1,  7'd20, 2'b00, 1'b0, 1'b0}, // 16 R3
    {1'b1, 2'b00, 7'd20, 1'b1,  7'd20, 2'b00, 1'b0, 1'b0}, // 17 R6
    {1'b1, 2'b00, 7'd33, 1'b0,  7'd33, 2'b00, 1'b0, 1'b0}, // 18 R6 tracking
    {1'b1, 2'b10, 7'd33, 1'b0,  7'd0,  2'b00, 1'b0, 1'b0}, // 19 R4
    {1'b0, 2'b10, 7'd33, 1'b0,  7'd0,  2'b00, 1'b0, 1'b0}, // 20 R8 held
    {1'b0, 2'b10, 7'd33, 1'b1,  7'd0,  2'b00, 1'b0, 1'b0}, // 21 R5
    {1'b0, 2'b10, 7'd33, 1'b0,  7'd33, 2'b10, 1'b0, 1'b0}, // 22 R8 no pd yet
    {1'b0, 2'b10, 7'd33, 1'b1,  7'd33, 2'b10, 1'b0, 1'b0}, // 23 R3
    {1'b0, 2'b10, 7'd33, 1'b1,  7'd33, 2'b10, 1'b0, 1'b0}, // 24 R6
    {1'b0, 2'b10, 7'd33, 1'b0,  7'd0,  2'b10, 1'b0, 1'b0}  // 25 R7
  };
  localparam int REQ [NV] = '{9,2,3,2,6,4,3,5,5,3,6,8,7,7,7,2,3,6,6,4,8,5,8,3,6,7};

  task automatic check(input int req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual tgt=%0d filt=%b pd=%b done=%b expected tgt=%0d filt=%b pd=%b done=%b",
               req, act[10:4], act[3:2], act[1], act[0], exp[10:4], exp[3:2], exp[1], exp[0]);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    host_lvl = 7'd40;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, {vol_tgt, filt_en, dp_pwrdn, pd_done}, {7'd0, 2'b00, 1'b1, 1'b1});
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {pwr_on, filt_req, host_lvl, settled} = VEC[i][21:11];
      @(negedge clk);
      check(REQ[i], {vol_tgt, filt_en, dp_pwrdn, pd_done}, VEC[i][10:0]);
    end
    // R1 reset in the middle of the power-down ramp
    pwr_on = 1'b0; settled = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, {vol_tgt, filt_en, dp_pwrdn, pd_done}, {7'd0, 2'b00, 1'b1, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    // R9 powered-down: filter request applied, target stays muted
    filt_req = 2'b11;
    @(negedge clk);
    check(9, {vol_tgt, filt_en, dp_pwrdn, pd_done}, {7'd0, 2'b11, 1'b1, 1'b1});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule